// File: doc/BRIEF.md
# Per-Flow Packet and Byte Counter Table

This block keeps a packet count and a byte count for every entry of a flow table. Each cycle a packet event may arrive carrying a flow index, a packet length and a count-enable flag taken from that flow's entry. When counting is globally enabled and the flag is set, the entry's packet count goes up by one and its byte count goes up by the packet length. The counters are 40 bits for packets and 48 bits for bytes.

Software reaches the counters through a small register port. It writes a command word holding an entry index and a start bit, polls until the busy bit drops, and then reads three result words. A configuration bit makes each completed read zero the entry, so that successive reads return the traffic seen since the last read. A separate command variant zeroes one entry without returning anything. The counters sit in a single-port store. Packet updates always win the port, and a pending software access is served in the first cycle with no counted packet. After reset the block sweeps zeros through every entry before it accepts any work.

Top module: `flow_acct_table`

## Requirements
- R1: After reset the block writes zero into every entry, one entry per cycle for ENTRIES cycles. During this sweep the busy bit (command word bit 16) reads 1, command writes are ignored and no packet is counted.
- R2: Register address 0 is configuration. Bit 0 is the global count enable and bit 1 is read-clear. Both reset to 0 and read back as written.
- R3: Register address 1 is the command word. Bits 13:0 are the entry index, bit 16 is start (on write) and busy (on read), and bit 17 selects a clear command. A write with bit 16 at 0 does nothing. Only the low log2(ENTRIES) bits of an index select the entry, for both packets and commands.
- R4: A packet with pkt_valid, pkt_cnt_en and global enable all at 1 adds 1 to its entry's packet count and pkt_len to its byte count, modulo 2^40 and 2^48.
- R5: A packet with pkt_cnt_en at 0, or one that arrives while global enable is 0, leaves every count unchanged.
- R6: After a read command the result words hold these values. Address 2 holds byte count bits 31:0. Address 3 holds byte count bits 47:32 in bits 15:0 and packet count bits 15:0 in bits 31:16. Address 4 holds packet count bits 39:16 in bits 23:0 and zero in bits 31:24.
- R7: With read-clear at 1, a served read zeroes the entry after capturing it. With read-clear at 0, a read leaves the entry unchanged.
- R8: A clear command (bit 17 set) zeroes the entry and leaves the result words unchanged.
- R9: While a counted packet arrives every cycle, a pending command stays busy. It is served in the first cycle with no counted packet, and its result includes every packet counted before that cycle.
- R10: A command write while busy is 1 is ignored. The index read back and the entry served are those of the first command.
- R11: The result words change only in the cycle in which a read command is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet event is present this cycle |
| pkt_idx | input | 14 | Flow index of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_cnt_en | input | 1 | Per-flow count-enable flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The checker watches several rules on every cycle. A pending command stays busy through cycles that carry a counted packet. A write to the command word while busy leaves the latched index unchanged. The result words never move while no command is pending. The padding byte of the third result word is always zero, and busy reads high throughout the reset sweep. Only the bench scenarios can show that the counts themselves are right: the sums over mixed vectors, the index aliasing, the read-clear delta behaviour, the clear command, disabled counting, and the result of a read delayed behind a packet burst.

// File: rtl/flow_acct_table.sv
module flow_acct_table #(
  parameter int ENTRIES = 1024,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [13:0]      pkt_idx,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             pkt_cnt_en,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  localparam int AW = $clog2(ENTRIES);

  logic [47:0] byt_mem [ENTRIES];
  logic [39:0] pkt_mem [ENTRIES];

  logic          cfg_en, cfg_rdclr;
  logic          cmd_busy, cmd_clr, init_run;
  logic [13:0]   cmd_idx;
  logic [AW-1:0] init_ptr;
  logic [47:0]   res_byt;
  logic [39:0]   res_pkt;

  wire [AW-1:0] pa = pkt_idx[AW-1:0];
  wire [AW-1:0] ca = cmd_idx[AW-1:0];
  wire busy    = cmd_busy | init_run;
  wire pkt_hit = pkt_valid & pkt_cnt_en & cfg_en & ~init_run;
  wire svc     = cmd_busy & ~init_run & ~pkt_hit;
  wire cmd_go  = reg_wr & (reg_addr == 3'd1) & reg_wdata[16] & ~busy;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:18], reg_wdata[15:14], pkt_idx};

  always_ff @(posedge clk) begin
    if (init_run) begin
      byt_mem[init_ptr] <= '0;
      pkt_mem[init_ptr] <= '0;
    end else if (pkt_hit) begin
      byt_mem[pa] <= byt_mem[pa] + 48'(pkt_len);
      pkt_mem[pa] <= pkt_mem[pa] + 40'd1;
    end else if (svc && (cmd_clr || cfg_rdclr)) begin
      byt_mem[ca] <= '0;
      pkt_mem[ca] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_run  <= 1'b1;
      init_ptr  <= '0;
      cfg_en    <= 1'b0;
      cfg_rdclr <= 1'b0;
      cmd_busy  <= 1'b0;
      cmd_clr   <= 1'b0;
      cmd_idx   <= '0;
      res_byt   <= '0;
      res_pkt   <= '0;
    end else begin
      if (init_run) begin
        init_ptr <= init_ptr + 1'b1;
        if (init_ptr == AW'(ENTRIES - 1)) init_run <= 1'b0;
      end
      if (reg_wr && reg_addr == 3'd0) begin
        cfg_en    <= reg_wdata[0];
        cfg_rdclr <= reg_wdata[1];
      end
      if (cmd_go) begin
        cmd_busy <= 1'b1;
        cmd_idx  <= reg_wdata[13:0];
        cmd_clr  <= reg_wdata[17];
      end else if (svc) begin
        cmd_busy <= 1'b0;
        if (!cmd_clr) begin
          res_byt <= byt_mem[ca];
          res_pkt <= pkt_mem[ca];
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {30'd0, cfg_rdclr, cfg_en};
      3'd1:    reg_rdata = {15'd0, busy, 2'd0, cmd_idx};
      3'd2:    reg_rdata = res_byt[31:0];
      3'd3:    reg_rdata = {res_pkt[15:0], res_byt[47:32]};
      3'd4:    reg_rdata = {8'd0, res_pkt[39:16]};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flow_acct_table_chk.sv
module flow_acct_table_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_hit,
  input logic        cmd_busy,
  input logic        init_run,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [13:0] cmd_idx,
  input logic [47:0] res_byt,
  input logic [39:0] res_pkt
);
  assert_init_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (init_run && reg_addr == 3'd1) |-> reg_rdata[16]);

  assert_word2_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd4) |-> (reg_rdata[31:24] == 8'd0));

  assert_hold_behind_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && pkt_hit) |=> cmd_busy);

  assert_drop_idle_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> !$past(pkt_hit));

  assert_cmd_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_busy || init_run) && reg_wr && reg_addr == 3'd1) |=> $stable(cmd_idx));

  assert_res_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |=> ($stable(res_byt) && $stable(res_pkt)));
endmodule

bind flow_acct_table flow_acct_table_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_hit(pkt_hit), .cmd_busy(cmd_busy),
  .init_run(init_run), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .cmd_idx(cmd_idx), .res_byt(res_byt), .res_pkt(res_pkt)
);

// File: tb/flow_acct_table_test.sv
module flow_acct_table_test;
  localparam int ENT = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_valid = 1'b0, pkt_cnt_en = 1'b0, reg_wr = 1'b0;
  logic [13:0] pkt_idx = '0;
  logic [15:0] pkt_len = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int checks = 0, fails = 0;
  logic [47:0] mb [ENT];
  logic [39:0] mp [ENT];

  always #5 clk = ~clk;

  flow_acct_table uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_idx(pkt_idx),
    .pkt_len(pkt_len), .pkt_cnt_en(pkt_cnt_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {cnt_en, idx[13:0], len[15:0]}
  localparam logic [30:0] VEC [12] = '{
    {1'b1, 14'd2,    16'd64},   {1'b1, 14'd2,  16'd1500},
    {1'b1, 14'd5,    16'd40},   {1'b0, 14'd2,  16'd9000},
    {1'b1, 14'd5,    16'd65535},{1'b1, 14'd1029, 16'd100},
    {1'b1, 14'd8,    16'd1},    {1'b1, 14'd8,  16'd0},
    {1'b0, 14'd13,   16'd256},  {1'b1, 14'd2,  16'd77},
    {1'b1, 14'd5,    16'd1},    {1'b1, 14'd8,  16'd1514}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (!s[16]) break;
      @(negedge clk);
    end
  endtask

  task automatic pkt(input logic [13:0] idx, input logic [15:0] len, input logic en);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_idx = idx; pkt_len = len; pkt_cnt_en = en;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input int idx, input logic clr,
                          input logic [47:0] eb, input logic [39:0] ep);
    logic [31:0] w;
    wr(3'd1, 32'h10000 | (32'(clr) << 17) | 32'(idx));
    wait_idle();
    rd(3'd2, w); chk(req, w, eb[31:0]);
    rd(3'd3, w); chk(req, w, {ep[15:0], eb[47:32]});
    rd(3'd4, w); chk(req, w, {8'd0, ep[39:16]});
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-all got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < ENT; i++) begin mb[i] = '0; mp[i] = '0; end
    repeat (3) @(negedge clk);
    rd(3'd0, s); chk("R2 reset config", s, 32'd0);
    rd(3'd1, s); chk("R1 busy in reset", {31'd0, s[16]}, 1);
    @(negedge clk); rst_n = 1'b1;
    wr(3'd1, 32'h10006);
    rd(3'd1, s); chk("R1 busy during sweep", {31'd0, s[16]}, 1);
    wait_idle();
    rd(3'd1, s); chk("R1 command ignored in sweep", s, 32'd0);
    read_chk("R1 swept entry zero", 7, 1'b0, 48'd0, 40'd0);

    wr(3'd1, 32'h00000021);
    rd(3'd1, s); chk("R3 no start no command", s, 32'd7);
    wr(3'd0, 32'd1);
    rd(3'd0, s); chk("R2 config readback", s, 32'd1);

    for (int v = 0; v < 12; v++) begin
      int i;
      i = int'(VEC[v][29:16]) % ENT;
      pkt(VEC[v][29:16], VEC[v][15:0], VEC[v][30]);
      if (VEC[v][30]) begin
        mb[i] = mb[i] + 48'(VEC[v][15:0]);
        mp[i] = mp[i] + 40'd1;
      end
    end
    read_chk("R4 R6 entry 2", 2, 1'b0, mb[2], mp[2]);
    read_chk("R3 R4 aliased entry 5", 5, 1'b0, mb[5], mp[5]);
    read_chk("R4 entry 8", 8, 1'b0, mb[8], mp[8]);
    read_chk("R5 flag off entry 13", 13, 1'b0, 48'd0, 40'd0);
    read_chk("R7 no read-clear keeps", 2, 1'b0, 48'd1641, 40'd3);

    wr(3'd0, 32'd3);
    read_chk("R7 read-clear returns", 2, 1'b0, 48'd1641, 40'd3);
    read_chk("R7 read-clear zeroed", 2, 1'b0, 48'd0, 40'd0);

    wr(3'd0, 32'd0);
    pkt(14'd5, 16'd10, 1'b1);
    wr(3'd0, 32'd1);
    read_chk("R5 disabled no count", 5, 1'b0, 48'd65676, 40'd4);

    pkt(14'd20, 16'd300, 1'b1);
    read_chk("R4 entry 20", 20, 1'b0, 48'd300, 40'd1);
    pkt(14'd20, 16'd50, 1'b1);
    wr(3'd1, 32'h30000 | 32'd20);
    wait_idle();
    rd(3'd2, s); chk("R8 clear keeps result", s, 32'd300);
    rd(3'd3, s); chk("R8 clear keeps result", s, 32'h00010000);
    read_chk("R8 entry cleared", 20, 1'b0, 48'd0, 40'd0);

    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h10000 | 32'd9;
    pkt_valid = 1'b1; pkt_idx = 14'd9; pkt_len = 16'd100; pkt_cnt_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rd(3'd1, s); chk("R9 busy behind packets", {31'd0, s[16]}, 1);
      if (k == 1) begin reg_wr = 1'b1; reg_wdata = 32'h10000 | 32'd11; end
      else reg_wr = 1'b0;
      @(negedge clk);
    end
    pkt_valid = 1'b0; reg_wr = 1'b0;
    wait_idle();
    rd(3'd1, s); chk("R10 busy write ignored", s, 32'd9);
    rd(3'd2, s); chk("R9 served after burst", s, 32'd500);
    rd(3'd3, s); chk("R9 served after burst", s, 32'h00050000);

    report();
  end
endmodule